// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It reads a context table and then up to three levels of page tables held in memory. A requester presents a virtual address together with three attributes: whether the access is a write, whether it is an instruction fetch, and whether it runs in supervisor mode. The walker then fetches table entries one word at a time over a simple memory port and stops at the first leaf entry it finds. A leaf at the first, second or third level maps a 16 MB, 256 KB or 4 KB region.

When the walker reaches a leaf, it sets the leaf's accessed flag. For a write it also sets the modified flag, and it writes the entry back to memory when either flag changes. It then checks the access against the leaf's three-bit permission code. It answers with a single done pulse that carries either a physical address with read and write permission, or a fault. Faults are recorded in a sticky status register and a fault-address register. A small register port gives software access to these two registers and to the enable, table-pointer and context registers.

Top module: `ptw_top`

## Requirements
- R1: When bit 0 of the control register (index 0) is 0, a request completes without any memory access. The physical address equals the zero-extended virtual address, and both read and write permission are granted.
- R2: The first fetch of a walk reads the word at byte address (table pointer register << 4) + (context register << 4). The table pointer register is at index 1 and the context register at index 2.
- R3: Bits [1:0] of each fetched entry give its kind: 0 invalid, 1 pointer, 2 leaf, 3 reserved. A pointer leads to byte address ((entry with bits [1:0] cleared) << 4) + 4 × index. The index comes from virtual address bits [31:24], [23:18] or [17:12] for the first, second or third level.
- R4: A leaf at level 1, 2 or 3 yields the physical address (leaf bits [31:8] << 12) + offset. The offset is virtual address bits [23:0], [17:0] or [11:0] respectively.
- R5: Bit 5 of a leaf is the accessed flag and bit 6 is the modified flag. The walker writes the leaf back to the same address, with bit 5 set and with bit 6 also set for a write, exactly when bit 5 was clear or when a write found bit 6 clear. Otherwise it performs no write.
- R6: The access index is {write, fetch, supervisor}. Together with the leaf's permission field in bits [4:2], it selects a code from a fixed 8×8 table. A nonzero code is a fault with that code. A leaf write-back still takes place when a permission fault occurs.
- R7: Write permission is granted only when the leaf, after its update, has the modified flag set. In supervisor mode the permission code must also be odd. In user mode the permission code must be 1 or 3.
- R8: An invalid entry faults with code 1. A reserved entry, a leaf read from the context table, and a pointer found at the third level each fault with code 4.
- R9: On a fault, the status register (index 3) first becomes 1 if it was nonzero and is then ORed with (access index << 5) | (code << 2) | 2. The fault-address register (index 4) receives the virtual address.
- R10: Only one request is in flight at a time. Ready is low from acceptance until the done pulse. The done pulse comes only after any write-back has been acknowledged, and a memory request holds its address until it is acknowledged.
- R11: All registers reset to 0, read back what was written, and indices 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker idle, request accepted this cycle |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | Access is a write |
| reqCode | input | 1 | Access is an instruction fetch |
| reqSuper | input | 1 | Access is in supervisor mode |
| rspDone | output | 1 | One-cycle completion pulse |
| rspFault | output | 1 | Request faulted |
| rspPaddr | output | 36 | Translated physical address |
| rspRdOk | output | 1 | Read permitted |
| rspWrOk | output | 1 | Write permitted |
| memReq | output | 1 | Memory transaction pending |
| memWe | output | 1 | Transaction is a write |
| memAddr | output | 36 | Byte address of the table word |
| memWdata | output | 32 | Write-back data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Transaction complete |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register index |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data (combinational) |

## Verification
The bench maps one virtual region at each of the three levels. It then runs the same leaf through a read, a write and a second read, which exposes a design that writes back every time or never marks the entry modified. Invalid, reserved, misplaced-leaf and third-level-pointer entries target a walker that follows an illegal entry or reports the wrong code. Two faults in a row without clearing the status register show whether the overflow bit is lost or whether stale fields fail to accumulate. A user read of a supervisor-only page catches a design that skips the write-back on a permission fault. A bypass request catches one that touches memory while translation is off.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ACC_BIT = 5;
  localparam int MOD_BIT = 6;

  typedef enum logic [1:0] {
    ENT_INVALID  = 2'd0,
    ENT_TABLE    = 2'd1,
    ENT_LEAF     = 2'd2,
    ENT_RESERVED = 2'd3
  } entKind_t;

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_WRITE, W_DONE} walkState_t;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_TPTR = 3'd1;
  localparam logic [2:0] REG_CTX  = 3'd2;
  localparam logic [2:0] REG_FSTS = 3'd3;
  localparam logic [2:0] REG_FADR = 3'd4;

  typedef struct packed {
    logic       accept;
    logic       passThru;
    logic       descend;
    logic       leafHit;
    logic       fault;
    logic [2:0] faultCode;
    logic [1:0] level;
  } walkStrobe_t;

  // Permission outcome: row = access index, 2-bit field per permission code.
  function automatic logic [1:0] permLookup(input logic [2:0] accIdx, input logic [2:0] perm);
    logic [15:0] row;
    case (accIdx)
      3'd0: row = 16'hF200;
      3'd1: row = 16'h0200;
      3'd2: row = 16'hF80A;
      3'd3: row = 16'h080A;
      3'd4: row = 16'hFA22;
      3'd5: row = 16'h2222;
      3'd6: row = 16'hFA2A;
      default: row = 16'h2A2A;
    endcase
    return row[{perm, 1'b0} +: 2];
  endfunction
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        xlateOn,
  input  logic        memAck,
  input  logic [1:0]  entKind,
  input  logic [1:0]  permCode,
  input  logic        needWb,
  output walkStrobe_t stb,
  output logic        reqReady,
  output logic        rspDone,
  output logic        memReq,
  output logic        memWe
);
  walkState_t state, stateNx;
  logic [1:0] lvl, lvlNx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= W_IDLE;
      lvl   <= 2'd0;
    end else begin
      state <= stateNx;
      lvl   <= lvlNx;
    end
  end

  always_comb begin
    stb       = '0;
    stb.level = lvl;
    stateNx   = state;
    lvlNx     = lvl;
    case (state)
      W_IDLE: if (reqValid) begin
        stb.accept = 1'b1;
        lvlNx      = 2'd0;
        if (!xlateOn) begin
          stb.passThru = 1'b1;
          stateNx      = W_DONE;
        end else begin
          stateNx = W_FETCH;
        end
      end
      W_FETCH: if (memAck) begin
        case (entKind)
          ENT_INVALID: begin
            stb.fault = 1'b1; stb.faultCode = 3'd1; stateNx = W_DONE;
          end
          ENT_TABLE: begin
            if (lvl == 2'd3) begin
              stb.fault = 1'b1; stb.faultCode = 3'd4; stateNx = W_DONE;
            end else begin
              stb.descend = 1'b1; lvlNx = lvl + 2'd1;
            end
          end
          ENT_LEAF: begin
            if (lvl == 2'd0) begin
              stb.fault = 1'b1; stb.faultCode = 3'd4; stateNx = W_DONE;
            end else begin
              stb.leafHit = 1'b1;
              if (permCode != 2'd0) begin
                stb.fault = 1'b1; stb.faultCode = {1'b0, permCode};
              end
              stateNx = needWb ? W_WRITE : W_DONE;
            end
          end
          default: begin
            stb.fault = 1'b1; stb.faultCode = 3'd4; stateNx = W_DONE;
          end
        endcase
      end
      W_WRITE: if (memAck) stateNx = W_DONE;
      default: stateNx = W_IDLE;
    endcase
  end

  assign reqReady = (state == W_IDLE);
  assign rspDone  = (state == W_DONE);
  assign memReq   = (state == W_FETCH) || (state == W_WRITE);
  assign memWe    = (state == W_WRITE);

  // R10
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> reqReady);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && (memWe == $past(memWe)));
endmodule

// File: rtl/ptw_dp.sv
module ptw_dp
  import ptw_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       stb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic              reqCode,
  input  logic              reqSuper,
  input  logic [VA_W-1:0]   memRdata,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [VA_W-1:0]   cfgWdata,
  output logic              xlateOn,
  output logic [1:0]        permCode,
  output logic              needWb,
  output logic [VA_W+3:0]   memAddr,
  output logic [VA_W-1:0]   memWdata,
  output logic [VA_W-1:0]   cfgRdata,
  output logic              rspFault,
  output logic [VA_W+3:0]   rspPaddr,
  output logic              rspRdOk,
  output logic              rspWrOk
);
  localparam int PA_W = VA_W + 4;

  logic [VA_W-1:0] vaQ, wbData, ctrlReg, tptrReg, ctxReg, fstsReg, fadrReg;
  logic [2:0]      accIdxQ;
  logic [PA_W-1:0] walkAddr;

  logic [VA_W-1:0] leafUpd;
  logic [2:0]      permF;
  logic [7:0]      tblIdx;
  logic [PA_W-1:0] descAddr, ctxAddr, leafOfs, leafPa;
  logic            wrOk;
  logic [VA_W-1:0] fstsNext;

  wire isWr  = accIdxQ[2];
  wire isSup = accIdxQ[0];

  assign leafUpd  = memRdata | (VA_W'(1) << ACC_BIT) | (VA_W'(isWr) << MOD_BIT);
  assign needWb   = !memRdata[ACC_BIT] || (isWr && !memRdata[MOD_BIT]);
  assign permF    = leafUpd[4:2];
  assign permCode = permLookup(accIdxQ, permF);
  assign wrOk     = leafUpd[MOD_BIT] && (isSup ? permF[0] : (permF == 3'd1 || permF == 3'd3));

  always_comb begin
    case (stb.level)
      2'd0:    tblIdx = vaQ[31:24];
      2'd1:    tblIdx = {2'b00, vaQ[23:18]};
      default: tblIdx = {2'b00, vaQ[17:12]};
    endcase
    case (stb.level)
      2'd1:    leafOfs = PA_W'(vaQ[23:0]);
      2'd2:    leafOfs = PA_W'(vaQ[17:0]);
      default: leafOfs = PA_W'(vaQ[11:0]);
    endcase
  end

  assign descAddr = {memRdata[VA_W-1:2], 6'b0} + {{(PA_W-10){1'b0}}, tblIdx, 2'b00};
  assign ctxAddr  = {tptrReg, 4'b0} + {ctxReg, 4'b0};
  assign leafPa   = {memRdata[VA_W-1:8], 12'b0} + leafOfs;
  assign fstsNext = VA_W'(fstsReg != '0) | {{(VA_W-8){1'b0}}, accIdxQ, stb.faultCode, 2'b10};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; accIdxQ <= '0; walkAddr <= '0; wbData <= '0;
      rspFault <= 1'b0; rspPaddr <= '0; rspRdOk <= 1'b0; rspWrOk <= 1'b0;
      ctrlReg <= '0; tptrReg <= '0; ctxReg <= '0; fstsReg <= '0; fadrReg <= '0;
    end else begin
      if (stb.accept) begin
        vaQ      <= reqVaddr;
        accIdxQ  <= {reqWrite, reqCode, reqSuper};
        walkAddr <= ctxAddr;
      end
      if (stb.passThru) begin
        rspPaddr <= PA_W'(reqVaddr);
        rspRdOk  <= 1'b1; rspWrOk <= 1'b1; rspFault <= 1'b0;
      end
      if (stb.descend) walkAddr <= descAddr;
      if (stb.leafHit) begin
        wbData   <= leafUpd;
        rspPaddr <= leafPa;
        rspRdOk  <= 1'b1; rspWrOk <= wrOk; rspFault <= 1'b0;
      end
      if (stb.fault) begin
        rspFault <= 1'b1; rspPaddr <= '0; rspRdOk <= 1'b0; rspWrOk <= 1'b0;
      end
      if (cfgWe) begin
        case (cfgAddr)
          REG_CTRL: ctrlReg <= cfgWdata;
          REG_TPTR: tptrReg <= cfgWdata;
          REG_CTX:  ctxReg  <= cfgWdata;
          REG_FSTS: fstsReg <= cfgWdata;
          REG_FADR: fadrReg <= cfgWdata;
          default: ;
        endcase
      end
      if (stb.fault) begin
        fstsReg <= fstsNext;
        fadrReg <= vaQ;
      end
    end
  end

  always_comb begin
    case (cfgAddr)
      REG_CTRL: cfgRdata = ctrlReg;
      REG_TPTR: cfgRdata = tptrReg;
      REG_CTX:  cfgRdata = ctxReg;
      REG_FSTS: cfgRdata = fstsReg;
      REG_FADR: cfgRdata = fadrReg;
      default:  cfgRdata = '0;
    endcase
  end

  assign xlateOn  = ctrlReg[0];
  assign memAddr  = walkAddr;
  assign memWdata = wbData;

  // R9
  fault_log_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fault |=> fstsReg[1] && (fadrReg == vaQ));
  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.passThru |=> rspRdOk && rspWrOk && (rspPaddr == PA_W'($past(reqVaddr))));
  // R7
  wr_needs_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.leafHit && !leafUpd[MOD_BIT] |=> !rspWrOk);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic            reqWrite,
  input  logic            reqCode,
  input  logic            reqSuper,
  output logic            rspDone,
  output logic            rspFault,
  output logic [VA_W+3:0] rspPaddr,
  output logic            rspRdOk,
  output logic            rspWrOk,
  output logic            memReq,
  output logic            memWe,
  output logic [VA_W+3:0] memAddr,
  output logic [VA_W-1:0] memWdata,
  input  logic [VA_W-1:0] memRdata,
  input  logic            memAck,
  input  logic            cfgWe,
  input  logic [2:0]      cfgAddr,
  input  logic [VA_W-1:0] cfgWdata,
  output logic [VA_W-1:0] cfgRdata
);
  walkStrobe_t stb;
  logic        xlateOn, needWb;
  logic [1:0]  permCode;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .xlateOn(xlateOn), .memAck(memAck),
    .entKind(memRdata[1:0]), .permCode(permCode), .needWb(needWb), .stb(stb),
    .reqReady(reqReady), .rspDone(rspDone), .memReq(memReq), .memWe(memWe)
  );

  ptw_dp #(.VA_W(VA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .reqCode(reqCode), .reqSuper(reqSuper), .memRdata(memRdata), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .xlateOn(xlateOn), .permCode(permCode),
    .needWb(needWb), .memAddr(memAddr), .memWdata(memWdata), .cfgRdata(cfgRdata),
    .rspFault(rspFault), .rspPaddr(rspPaddr), .rspRdOk(rspRdOk), .rspWrOk(rspWrOk)
  );

  // R5
  wb_sets_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[ACC_BIT]);
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));
endmodule

// File: tb/sim_ptw_top.sv
`timescale 1ns/1ps
module sim_ptw_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqCode = 1'b0, reqSuper = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqReady, rspDone, rspFault, rspRdOk, rspWrOk;
  logic [35:0] rspPaddr, memAddr;
  logic        memReq, memWe;
  logic [31:0] memWdata, cfgRdata;
  logic [31:0] memRdata;
  logic        memAck;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;

  int checks = 0, failures = 0, wrCount = 0;
  logic [31:0] ram [logic [35:0]];
  logic [31:0] ctrlS = 0, tptrS = 0, ctxS = 0, fstsS = 0, fadrS = 0;

  int accTab [64] = '{
    0,0,0,0,2,0,3,3,  0,0,0,0,2,0,0,0,
    2,2,0,0,0,2,3,3,  2,2,0,0,0,2,0,0,
    2,0,2,0,2,2,3,3,  2,0,2,0,2,0,2,0,
    2,2,2,0,2,2,3,3,  2,2,2,0,2,2,2,0};

  always #4 clk = ~clk;

  ptw_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqCode(reqCode), .reqSuper(reqSuper), .rspDone(rspDone),
    .rspFault(rspFault), .rspPaddr(rspPaddr), .rspRdOk(rspRdOk), .rspWrOk(rspWrOk),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata)
  );

  function automatic logic [31:0] peek(input logic [35:0] a);
    return ram.exists(a) ? ram[a] : 32'h0;
  endfunction

  // memory model: acknowledges every other cycle, writes on acknowledge
  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0; memRdata = '0;
    end else if (memReq && !memAck) begin
      memAck = 1'b1;
      if (memWe) begin ram[memAddr] = memWdata; wrCount++; end
      else memRdata = peek(memAddr);
    end else begin
      memAck = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(posedge clk); #1 cfgWe = 1'b0;
    case (a) 0: ctrlS = d; 1: tptrS = d; 2: ctxS = d; 3: fstsS = d; 4: fadrS = d; default: ; endcase
  endtask

  task automatic readReg(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); cfgAddr = a; #1;
    chk(cfgRdata == exp, req, "register read", cfgRdata, exp);
  endtask

  task automatic xlate(input logic [31:0] va, input bit wr, input bit cd, input bit sp, input string req);
    bit eFault = 0, eRd = 0, eWr = 0, eWb = 0;
    int code = 0, ai, lv, pageLv = 0, w0;
    logic [35:0] a, ePa = '0;
    logic [31:0] e = '0, ne;
    ai = (wr ? 4 : 0) + (cd ? 2 : 0) + (sp ? 1 : 0);
    if (ctrlS[0] == 1'b0) begin
      ePa = 36'(va); eRd = 1; eWr = 1;
    end else begin
      a = (36'(tptrS) << 4) + (36'(ctxS) << 4);
      for (lv = 0; lv < 4; lv++) begin
        e = peek(a);
        if (e[1:0] == 2'd0) begin code = 1; break; end
        if (e[1:0] == 2'd3) begin code = 4; break; end
        if (e[1:0] == 2'd1) begin
          int idx;
          if (lv == 3) begin code = 4; break; end
          idx = (lv == 0) ? int'(va >> 24) : (lv == 1) ? int'((va >> 18) & 63) : int'((va >> 12) & 63);
          a = (36'(e & 32'hFFFF_FFFC) << 4) + 36'(idx * 4);
        end else begin
          if (lv == 0) begin code = 4; break; end
          pageLv = lv; break;
        end
      end
      if (code == 0) begin
        int ob, perm;
        eWb = (e[5] == 1'b0) || (wr && e[6] == 1'b0);
        ne = e | 32'h20 | (wr ? 32'h40 : 32'h0);
        perm = int'(ne[4:2]);
        code = accTab[ai * 8 + perm];
        if (code == 0) begin
          ob = (pageLv == 1) ? 24 : (pageLv == 2) ? 18 : 12;
          ePa = {e[31:8], 12'h0} + (36'(va) & ((36'd1 << ob) - 36'd1));
          eRd = 1;
          eWr = ne[6] && (sp ? (perm % 2 == 1) : (perm == 1 || perm == 3));
        end
      end
      if (code != 0) begin
        eFault = 1;
        fstsS = ((fstsS != 0) ? 32'd1 : 32'd0) | 32'(ai << 5) | 32'(code << 2) | 32'd2;
        fadrS = va;
      end
    end
    w0 = wrCount;
    @(negedge clk); reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqCode = cd; reqSuper = sp;
    @(posedge clk); @(negedge clk); reqValid = 1'b0;
    chk(reqReady == 1'b0, "R10", "busy after accept", reqReady, 0);
    while (!rspDone) @(negedge clk);
    chk(rspFault == eFault, req, "fault flag", rspFault, eFault);
    chk(rspPaddr == ePa, req, "physical address", rspPaddr, ePa);
    chk(rspRdOk == eRd && rspWrOk == eWr, req, "permissions {rd,wr}", {rspRdOk, rspWrOk}, {eRd, eWr});
    chk(wrCount - w0 == (eWb ? 1 : 0), "R5", "write-back count", wrCount - w0, eWb);
    if (eWb) chk(peek(a) == ne, "R5", "written entry", peek(a), ne);
    if (eFault) begin
      readReg(3, fstsS, "R9");
      readReg(4, fadrS, "R9");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ram[36'h10020] = 32'h0000_2001;   // context 2 -> level-1 table 0x20000
    ram[36'h10030] = 32'h0000_0E02;   // context 3 holds a leaf (illegal)
    ram[36'h20048] = 32'h0000_3001;   // L1[0x12] -> L2 table 0x30000
    ram[36'h201DC] = 32'h0012_3466;   // L1[0x77] leaf, perm 1, acc+mod
    ram[36'h20198] = 32'h0000_0003;   // L1[0x66] reserved
    ram[36'h30034] = 32'h0000_4001;   // L2[0x0D] -> L3 table 0x40000
    ram[36'h3008C] = 32'h00FF_002A;   // L2[0x23] leaf, perm 2, acc set
    ram[36'h40014] = 32'hF00A_BC0E;   // L3[5] leaf, perm 3, flags clear
    ram[36'h4001C] = 32'h0000_5001;   // L3[7] pointer at last level
    ram[36'h40020] = 32'h0077_001A;   // L3[8] leaf, perm 6, flags clear
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && rspDone == 1'b0 && memReq == 1'b0, "R11", "reset outputs",
        {reqReady, rspDone, memReq}, 3'b100);
    for (int r = 0; r < 8; r++) readReg(3'(r), 32'h0, "R11");
    writeReg(0, 32'h1); writeReg(1, 32'h1000); writeReg(2, 32'h2);
    readReg(1, 32'h1000, "R11");
    xlate(32'h1234_5678, 0, 0, 1, "R2/R3/R4");   // level-3 read, sets accessed
    xlate(32'h1234_5678, 1, 0, 1, "R7");         // write sets modified
    xlate(32'h1234_5678, 0, 0, 1, "R4");         // no write-back now
    xlate(32'h7700_1234, 0, 0, 0, "R4");         // level-1 mapping, user read
    xlate(32'h7700_1234, 1, 0, 0, "R7");         // user write, perm 1
    xlate(32'h128C_0ABC, 0, 1, 1, "R4");         // level-2 mapping, fetch
    xlate(32'h1234_6000, 0, 0, 1, "R8");         // invalid at level 3
    xlate(32'h5500_0000, 1, 0, 0, "R9");         // second fault: overflow
    writeReg(3, 32'h0);
    readReg(3, 32'h0, "R11");
    xlate(32'h6600_0000, 0, 0, 1, "R8");         // reserved entry
    xlate(32'h1234_7000, 0, 0, 1, "R8");         // pointer at level 3
    xlate(32'h1234_8000, 0, 0, 0, "R6");         // user read of supervisor page
    xlate(32'h1234_5000, 0, 1, 0, "R6");         // user fetch allowed
    writeReg(2, 32'h3);
    xlate(32'h0000_0000, 0, 0, 1, "R8");         // leaf at context level
    writeReg(0, 32'h0);
    xlate(32'hDEAD_BEEF, 1, 0, 0, "R1");         // bypass
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule